// File: doc/BRIEF.md
# Two-Channel Block-Transfer DMA Sequencer

The block decides which of two DMA channels uses an external bus and how many transfer cycles it runs there. Each channel holds a block size, a block count, an interrupt-enable bit and three status bits: active, interrupt flag and block error. When an active channel raises its transfer request and the sequencer is idle, the channel is granted. It then runs one whole block of bus cycles, with one cycle completed for each cycle in which `bus_req` and `bus_done` are both high. The sequencer then returns to idle. When requests collide, the lower-numbered channel wins. The winner keeps the bus until its block ends.

The block count drops by one for each finished block. When it runs out, the channel's active bit clears. One cycle later the interrupt flag sets, and one cycle after that the shared interrupt output rises if that channel's enable is set. Restarting a channel clears its flags. The abort input (a non-maskable interrupt) stops a running block immediately, clears every active bit and marks the channel that held the bus with a block error. A block size of 0 means 2^BW cycles, and a block count of 0 means 2^CW blocks.

Top module: `blkdma_seq`

## Requirements
- R1: After reset, `act`, `irf`, `bef`, `irq` and `bus_req` are all 0.
- R2: One granted request produces exactly the loaded block size of bus cycles for that channel, counting only cycles with `bus_done` high. `bus_ch` gives the channel index (0 or 1) throughout.
- R3: When the sequencer is idle and both active channels request, channel 0 is granted.
- R4: A granted channel keeps `bus_ch` and the bus until its block ends, even if channel 0 requests meanwhile. Priority is applied again only between blocks.
- R5: The block count drops once per finished block. After that many blocks the channel's `act` bit clears in the same cycle `bus_req` falls, and no further bus cycles follow.
- R6: `irf` of a finished channel rises one cycle after its `act` cleared. `irq` rises one cycle after that when the channel's interrupt enable is 1.
- R7: With the interrupt enable at 0, `irq` stays 0 although `irf` is set.
- R8: A start pulse sets `act` and clears `irf` and `bef` at the next edge. `irq` falls one cycle later.
- R9: Abort during a block drops `bus_req` at the next edge, clears `act` on all channels and sets `bef` only on the owning channel. It leaves `irf` at 0.
- R10: Abort with no block in progress clears `act` and leaves `bef` at 0.
- R11: A request from a channel whose `act` is 0 is ignored: no bus cycle is requested.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ld | input | 2 | Per-channel load strobe for size, count and enable |
| ld_size | input | BW | Block size to load |
| ld_count | input | CW | Block count to load |
| ld_ie | input | 1 | Interrupt enable to load |
| start | input | 2 | Per-channel start pulse (sets active) |
| xfer_req | input | 2 | Per-channel transfer request level |
| abort | input | 1 | Non-maskable abort |
| bus_done | input | 1 | Current bus cycle completes this edge |
| bus_req | output | 1 | Bus cycle requested |
| bus_ch | output | 1 | Channel owning the bus |
| act | output | 2 | Active bits |
| irf | output | 2 | Interrupt request flags |
| bef | output | 2 | Block error flags |
| irq | output | 1 | Interrupt output |

## Verification
The main function is tried in four situations: one channel requesting alone, both channels requesting at once, `bus_done` held high, and `bus_done` toggling. A lone request shows that the cycle count equals size times count. Two requests at once show priority and keep the two channels' cycle totals apart. A toggling `bus_done` shows that stall cycles are not counted as transfers. Directed runs follow:
- a request raised by channel 0 in the middle of a block, which separates holding the bus for the whole block from pre-emption;
- the interrupt flag and the interrupt output checked cycle by cycle around the end of the last block;
- abort inside a block and abort while idle, which show whether the block error is set.

// File: rtl/blkdma_pkg.sv
package blkdma_pkg;
  typedef enum logic {ENG_IDLE, ENG_BURST} eng_state_e;
endpackage

// File: rtl/blkdma_chan.sv
module blkdma_chan #(
  parameter int BW = 6,
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          ld,
  input  logic [BW-1:0] ld_size,
  input  logic [CW-1:0] ld_count,
  input  logic          ld_ie,
  input  logic          start,
  input  logic          abort,
  input  logic          blk_done,
  input  logic          abort_hit,
  output logic          act,
  output logic          irf,
  output logic          bef,
  output logic          ie,
  output logic [BW-1:0] size
);
  logic [CW-1:0] cnt_q;
  logic          pend_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      act    <= 1'b0;
      irf    <= 1'b0;
      bef    <= 1'b0;
      ie     <= 1'b0;
      size   <= '0;
      cnt_q  <= '0;
      pend_q <= 1'b0;
    end else begin
      if (ld) begin
        size  <= ld_size;
        cnt_q <= ld_count;
        ie    <= ld_ie;
      end
      // flag rises one cycle after the active bit has dropped
      if (pend_q) begin
        irf    <= 1'b1;
        pend_q <= 1'b0;
      end
      if (abort) begin
        act <= 1'b0;
        if (abort_hit) bef <= 1'b1;
      end else if (start) begin
        act    <= 1'b1;
        irf    <= 1'b0;
        bef    <= 1'b0;
        pend_q <= 1'b0;
      end else if (blk_done) begin
        cnt_q <= cnt_q - 1'b1;
        if (cnt_q == CW'(1)) begin
          act    <= 1'b0;
          pend_q <= 1'b1;
        end
      end
    end
  end

  AST_IRF_AFTER_ACT: assert property (@(posedge clk) disable iff (rst)
    $rose(irf) |-> (!act && $past(!act)));  // R6
  AST_BEF_ONLY_ABORT: assert property (@(posedge clk) disable iff (rst)
    $rose(bef) |-> $past(abort_hit));  // R9
endmodule

// File: rtl/blkdma_engine.sv
module blkdma_engine
  import blkdma_pkg::*;
#(
  parameter int NCH = 2,
  parameter int BW  = 6,
  localparam int CHW = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NCH-1:0]    ready,
  input  logic [NCH*BW-1:0] sizes,
  input  logic              abort,
  input  logic              bus_done,
  output logic              bus_req,
  output logic [CHW-1:0]    bus_ch,
  output logic [NCH-1:0]    blk_done,
  output logic [NCH-1:0]    abort_hit
);
  eng_state_e     state_q;
  logic [BW-1:0]  beat_q;
  logic [CHW-1:0] pick;
  logic           any;

  // fixed priority: lowest index wins (last assignment in the loop)
  always_comb begin
    pick = '0;
    any  = 1'b0;
    for (int i = NCH - 1; i >= 0; i--) begin
      if (ready[i]) begin
        pick = CHW'(i);
        any  = 1'b1;
      end
    end
  end

  assign bus_req = (state_q == ENG_BURST);

  always_comb begin
    blk_done  = '0;
    abort_hit = '0;
    if (bus_req && abort)
      abort_hit[bus_ch] = 1'b1;
    else if (bus_req && bus_done && beat_q == BW'(1))
      blk_done[bus_ch] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ENG_IDLE;
      bus_ch  <= '0;
      beat_q  <= '0;
    end else if (abort) begin
      state_q <= ENG_IDLE;
    end else if (state_q == ENG_BURST) begin
      if (bus_done) begin
        if (beat_q == BW'(1)) state_q <= ENG_IDLE;
        beat_q <= beat_q - 1'b1;
      end
    end else if (any) begin
      state_q <= ENG_BURST;
      bus_ch  <= pick;
      beat_q  <= sizes[pick*BW +: BW];
    end
  end

  AST_CH_STABLE: assert property (@(posedge clk) disable iff (rst)
    (bus_req && $past(bus_req)) |-> $stable(bus_ch));  // R4
  AST_ABORT_DROP: assert property (@(posedge clk) disable iff (rst)
    (abort && bus_req) |=> !bus_req);  // R9
  AST_NO_GRANT_ON_ABORT: assert property (@(posedge clk) disable iff (rst)
    (abort && !bus_req) |=> !bus_req);  // R10
endmodule

// File: rtl/blkdma_seq.sv
module blkdma_seq #(
  parameter int BW = 6,
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [1:0]    ld,
  input  logic [BW-1:0] ld_size,
  input  logic [CW-1:0] ld_count,
  input  logic          ld_ie,
  input  logic [1:0]    start,
  input  logic [1:0]    xfer_req,
  input  logic          abort,
  input  logic          bus_done,
  output logic          bus_req,
  output logic          bus_ch,
  output logic [1:0]    act,
  output logic [1:0]    irf,
  output logic [1:0]    bef,
  output logic          irq
);
  localparam int NCH = 2;

  logic [NCH-1:0]    ie;
  logic [NCH*BW-1:0] sizes;
  logic [NCH-1:0]    blk_done;
  logic [NCH-1:0]    abort_hit;

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    blkdma_chan #(.BW(BW), .CW(CW)) i_chan (
      .clk       (clk),
      .rst       (rst),
      .ld        (ld[g]),
      .ld_size   (ld_size),
      .ld_count  (ld_count),
      .ld_ie     (ld_ie),
      .start     (start[g]),
      .abort     (abort),
      .blk_done  (blk_done[g]),
      .abort_hit (abort_hit[g]),
      .act       (act[g]),
      .irf       (irf[g]),
      .bef       (bef[g]),
      .ie        (ie[g]),
      .size      (sizes[g*BW +: BW])
    );
  end

  blkdma_engine #(.NCH(NCH), .BW(BW)) i_engine (
    .clk       (clk),
    .rst       (rst),
    .ready     (act & xfer_req),
    .sizes     (sizes),
    .abort     (abort),
    .bus_done  (bus_done),
    .bus_req   (bus_req),
    .bus_ch    (bus_ch),
    .blk_done  (blk_done),
    .abort_hit (abort_hit)
  );

  always_ff @(posedge clk) begin
    if (rst) irq <= 1'b0;
    else     irq <= |(irf & ie);
  end

  AST_ONE_EVENT: assert property (@(posedge clk) disable iff (rst)
    $onehot0(blk_done | abort_hit));  // R4
  AST_IDLE_CH_IGNORED: assert property (@(posedge clk) disable iff (rst)
    (!bus_req && !(|(act & xfer_req))) |=> !bus_req);  // R11
endmodule

// File: tb/test_blkdma_seq.sv
`timescale 1ns/1ps
module test_blkdma_seq;
  localparam int BW = 6;
  localparam int CW = 8;

  logic clk = 1'b0;
  logic rst;
  logic [1:0] ld, start, xfer_req;
  logic [BW-1:0] ld_size;
  logic [CW-1:0] ld_count;
  logic ld_ie, abort, bus_done;
  logic bus_req, bus_ch, irq;
  logic [1:0] act, irf, bef;

  int nchk = 0;
  int nerr = 0;

  always #2 clk = ~clk;

  blkdma_seq #(.BW(BW), .CW(CW)) i_blkdma_seq (
    .clk(clk), .rst(rst), .ld(ld), .ld_size(ld_size), .ld_count(ld_count),
    .ld_ie(ld_ie), .start(start), .xfer_req(xfer_req), .abort(abort),
    .bus_done(bus_done), .bus_req(bus_req), .bus_ch(bus_ch), .act(act),
    .irf(irf), .bef(bef), .irq(irq)
  );

  // {size0, count0, size1, count1, req[1:0], stall}
  localparam int NV = 6;
  localparam logic [34:0] VEC [NV] = '{
    {8'd3, 8'd2, 8'd4, 8'd1, 2'b01, 1'b0},
    {8'd3, 8'd2, 8'd4, 8'd1, 2'b10, 1'b0},
    {8'd2, 8'd2, 8'd3, 8'd2, 2'b11, 1'b0},
    {8'd1, 8'd3, 8'd1, 8'd3, 2'b11, 1'b1},
    {8'd5, 8'd1, 8'd2, 8'd1, 2'b11, 1'b1},
    {8'd1, 8'd1, 8'd1, 8'd1, 2'b11, 1'b0}
  };

  task automatic chk(input bit ok, input string req, input int actual, input int expv);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s actual=%0d expected=%0d", req, actual, expv);
    end
  endtask

  task automatic do_reset();
    rst = 1'b1; ld = '0; start = '0; xfer_req = '0; abort = 1'b0;
    bus_done = 1'b0; ld_size = '0; ld_count = '0; ld_ie = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
  endtask

  task automatic load(input int ch, input int sz, input int cn, input bit ie);
    ld = 2'(1 << ch); ld_size = BW'(sz); ld_count = CW'(cn); ld_ie = ie;
    @(negedge clk);
    ld = '0;
  endtask

  task automatic go(input logic [1:0] m);
    start = m;
    @(negedge clk);
    start = '0;
  endtask

  task automatic wait_bus(input bit lvl);
    for (int k = 0; k < 200 && bus_req != lvl; k++) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nerr++; nchk++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

  initial begin
    int beats[2];
    int first;
    bit held;
    do_reset();
    // R1 reset state
    chk(act == 0 && irf == 0 && bef == 0 && !irq && !bus_req, "R1",
        {act, irf, bef, irq, bus_req}, 0);

    // vector table: R2 cycle totals, R3 first grant
    for (int v = 0; v < NV; v++) begin
      do_reset();
      load(0, int'(VEC[v][34:27]), int'(VEC[v][26:19]), 1'b1);
      load(1, int'(VEC[v][18:11]), int'(VEC[v][10:3]), 1'b1);
      xfer_req = VEC[v][2:1];
      go(VEC[v][2:1]);
      beats[0] = 0; beats[1] = 0; first = -1;
      for (int k = 0; k < 600; k++) begin
        bus_done = VEC[v][0] ? k[0] : 1'b1;
        if (bus_req && bus_done) begin
          if (first < 0) first = int'(bus_ch);
          beats[bus_ch]++;
        end
        if (!bus_req && act == 0) break;
        @(negedge clk);
      end
      xfer_req = '0; bus_done = 1'b0;
      chk(beats[0] == (VEC[v][1] ? int'(VEC[v][34:27]) * int'(VEC[v][26:19]) : 0),
          "R2 ch0", beats[0], VEC[v][1] ? int'(VEC[v][34:27]) * int'(VEC[v][26:19]) : 0);
      chk(beats[1] == (VEC[v][2] ? int'(VEC[v][18:11]) * int'(VEC[v][10:3]) : 0),
          "R2 ch1", beats[1], VEC[v][2] ? int'(VEC[v][18:11]) * int'(VEC[v][10:3]) : 0);
      chk(first == (VEC[v][1] ? 0 : 1), "R3", first, VEC[v][1] ? 0 : 1);
    end

    // R5 / R6 end of last block, flag and interrupt timing
    do_reset();
    load(0, 2, 1, 1'b1);
    xfer_req = 2'b01; bus_done = 1'b1;
    go(2'b01);
    wait_bus(1'b1);
    wait_bus(1'b0);
    xfer_req = '0;
    chk(act[0] == 1'b0, "R5", act[0], 0);
    chk(irf[0] == 1'b0, "R6 flag early", irf[0], 0);
    @(negedge clk);
    chk(irf[0] == 1'b1, "R6 flag", irf[0], 1);
    chk(irq == 1'b0, "R6 irq early", irq, 0);
    @(negedge clk);
    chk(irq == 1'b1, "R6 irq", irq, 1);
    chk(!bus_req, "R5 no more bus", bus_req, 0);

    // R8 restart clears flag, irq withdraws
    go(2'b01);
    chk(act[0] == 1'b1 && irf[0] == 1'b0, "R8 act/irf", {act[0], irf[0]}, 2);
    @(negedge clk);
    chk(irq == 1'b0, "R8 irq", irq, 0);

    // R10 abort while idle
    abort = 1'b1;
    @(negedge clk);
    abort = 1'b0;
    chk(act == 0 && bef == 0 && !bus_req, "R10", {act, bef}, 0);

    // R7 enable off
    do_reset();
    load(0, 1, 1, 1'b0);
    xfer_req = 2'b01; bus_done = 1'b1;
    go(2'b01);
    wait_bus(1'b1);
    wait_bus(1'b0);
    xfer_req = '0;
    repeat (3) @(negedge clk);
    chk(irf[0] == 1'b1 && irq == 1'b0, "R7", {irf[0], irq}, 2);

    // R9 abort mid block
    do_reset();
    load(0, 4, 1, 1'b1);
    load(1, 20, 1, 1'b1);
    go(2'b11);
    xfer_req = 2'b10; bus_done = 1'b1;
    wait_bus(1'b1);
    repeat (3) @(negedge clk);
    abort = 1'b1;
    @(negedge clk);
    abort = 1'b0;
    chk(!bus_req, "R9 bus", bus_req, 0);
    chk(act == 2'b00, "R9 act", act, 0);
    chk(bef == 2'b10, "R9 bef", bef, 2);
    @(negedge clk);
    chk(irf == 2'b00, "R9 irf", irf, 0);
    xfer_req = '0;

    // R4 ownership kept through block, priority between blocks
    do_reset();
    load(0, 2, 1, 1'b1);
    load(1, 5, 2, 1'b1);
    go(2'b11);
    xfer_req = 2'b10; bus_done = 1'b1;
    wait_bus(1'b1);
    chk(bus_ch == 1'b1, "R4 grant", bus_ch, 1);
    xfer_req = 2'b11;
    held = 1'b1;
    for (int k = 0; k < 50 && bus_req; k++) begin
      if (bus_ch != 1'b1) held = 1'b0;
      @(negedge clk);
    end
    chk(held, "R4 held", held, 1);
    wait_bus(1'b1);
    chk(bus_ch == 1'b0, "R3 between blocks", bus_ch, 0);
    xfer_req = '0; bus_done = 1'b0;

    // R11 inactive channel request ignored
    do_reset();
    load(1, 3, 1, 1'b1);
    xfer_req = 2'b10; bus_done = 1'b1;
    held = 1'b0;
    for (int k = 0; k < 6; k++) begin
      if (bus_req) held = 1'b1;
      @(negedge clk);
    end
    chk(!held && act == 0, "R11", held, 0);

    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule